// File: doc/BRIEF.md
# Vertical Sync, Field Parity and Line Standard Detector

This block runs one line at a time on a digitised video stream whose horizontal sync has already been separated. For every line it adds up how many clock cycles a sync-low sample is present, counting from the line-start strobe. A line whose low-time total goes above a programmable threshold holds a vertical sync pulse. The first such line of a field raises the vertical sync output and fixes the field parity from where in the line the crossing happened.

The block also counts the lines in each field. When two fields in a row disagree with the programmed line standard, it sets a sticky standard-error flag. If no line shows vertical sync for a long stretch, the block emits a one-cycle loss pulse that sends the phase-locked loops back to acquisition. It then keeps producing vertical sync and alternating field parity from a free-running line counter until real vertical sync comes back.

Top module: `vsd_detector`

## Requirements
- R1: The sync-low count restarts on the line-start cycle, where that cycle's sample is the first one counted. `vsync` rises in the cycle after the first sample of a line that takes the count above `vs_thresh`, provided `vsync` is low.
- R2: Once raised, `vsync` stays high while VS_LINES (default 6) line-start strobes arrive and falls in the cycle after the last of them. Crossings while it is high do not restart it.
- R3: `field` changes only as `vsync` rises. For a real crossing it is 0 (odd) when the crossing cycle's position in the line is below HALF_POS, and 1 (even) otherwise. Position 0 is the line-start cycle.
- R4: LOST_LINES (default 340, which is 337 plus 3) consecutive line-start strobes without a crossing produce a one-cycle `sync_lost` pulse in the cycle after the last such strobe. No further pulse follows until a crossing has been seen again.
- R5: After loss, a synthetic `vsync` starts after 262 and then 263 line strobes, alternating, for the 525-line standard (`std_625`=0), or after 312 and then 313 for the 625-line standard (`std_625`=1). `field` toggles at each synthetic start, and the durations follow R2.
- R6: Any crossing ends the lost state. Real detection then drives `vsync` and `field` again as in R1 and R3.
- R7: A field that has more than 285 line strobes between consecutive real `vsync` starts counts as 625-line. `std_err` sets when two measured fields in a row disagree with `std_625`. The first field after reset, clear or loss only serves as the reference.
- R8: `std_err` stays set until `std_clr` is pulsed or reset is applied. The clear also restarts the reference.
- R9: In reset, and on the first cycles after it, `vsync`, `field`, `sync_lost` and `std_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| sync_low | input | 1 | Sampled sync-low indication |
| vs_thresh | input | THR_W | Low-time count above which a line holds vertical sync |
| std_625 | input | 1 | Programmed standard: 0 = 525 lines, 1 = 625 lines |
| std_clr | input | 1 | Clears the standard-error flag (clock-ratio reload) |
| vsync | output | 1 | Vertical sync output |
| field | output | 1 | Field parity, 0 odd, 1 even |
| sync_lost | output | 1 | One-cycle pulse requesting PLL re-acquisition |
| std_err | output | 1 | Sticky standard mismatch flag |

## Verification
The properties assume that `line_start` is a single-cycle strobe and that lines are longer than the threshold. They also assume that `vs_thresh` and `std_625` change only between fields and that `std_clr` is a short pulse. The stimulus generates fixed 32-cycle lines with a constant threshold of 8, so short horizontal sync lows never cross it while vertical sync lows always do. It changes the standard only at field boundaries. Odd and even fields are produced by starting the long low at the line start or at mid-line, which gives the parity decision both outcomes.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } vsd_std_e;

    localparam int VSD_NTSC_MAX_LINES = 285;
    localparam int VSD_BASE_525       = 262;
    localparam int VSD_BASE_625       = 312;
endpackage

// File: rtl/vsd_line_meter.sv
module vsd_line_meter #(
    parameter int THR_W    = 10,
    parameter int POS_W    = 11,
    parameter int HALF_POS = 429
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             sync_low,
    input  logic [THR_W-1:0] vs_thresh,
    output logic             hit,
    output logic             hit_late
);
    localparam logic [THR_W-1:0] LOW_MAX = '1;
    localparam logic [POS_W-1:0] POS_MAX = '1;
    localparam logic [POS_W-1:0] HALF_V  = POS_W'(HALF_POS);

    typedef struct packed {
        logic [THR_W-1:0] low;
        logic [POS_W-1:0] pos;
        logic             crossed;
    } lm_s;

    lm_s q, d;

    always_comb begin
        d = q;
        if (line_start) begin
            d.low = {{(THR_W-1){1'b0}}, sync_low};
            d.pos = '0;
        end else begin
            if (sync_low && (q.low != LOW_MAX)) d.low = q.low + 1'b1;
            if (q.pos != POS_MAX)               d.pos = q.pos + 1'b1;
        end
        hit       = (d.low > vs_thresh) && (line_start || !q.crossed);
        hit_late  = hit && (d.pos >= HALF_V);
        d.crossed = line_start ? hit : (q.crossed | hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1: at most one crossing per line
    p_one_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!hit || line_start));
endmodule

// File: rtl/vsd_flywheel.sv
module vsd_flywheel #(
    parameter int LN_W       = 10,
    parameter int LOST_LINES = 340,
    parameter int BASE_525   = 262,
    parameter int BASE_625   = 312
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic hit,
    input  logic std_sel,
    output logic lost_enter,
    output logic lost_pulse,
    output logic fly_start
);
    localparam logic [LN_W-1:0] LOST_V = LN_W'(LOST_LINES);
    localparam logic [LN_W-1:0] B525_V = LN_W'(BASE_525);
    localparam logic [LN_W-1:0] B625_V = LN_W'(BASE_625);

    typedef struct packed {
        logic [LN_W-1:0] miss;
        logic [LN_W-1:0] fw;
        logic            ph;
        logic            lost;
        logic            pulse;
    } fw_s;

    fw_s q, d;
    logic [LN_W-1:0] miss_inc, fw_inc, period;

    always_comb begin
        d        = q;
        d.pulse  = 1'b0;
        miss_inc = q.miss + 1'b1;
        fw_inc   = q.fw + 1'b1;
        period   = (std_sel ? B625_V : B525_V) + {{(LN_W-1){1'b0}}, q.ph};

        if (hit)                                   d.miss = '0;
        else if (line_start && (q.miss != LOST_V)) d.miss = miss_inc;

        lost_enter = line_start && !hit && !q.lost && (miss_inc == LOST_V);
        fly_start  = q.lost && line_start && (fw_inc == period);

        if (lost_enter) begin
            d.lost  = 1'b1;
            d.pulse = 1'b1;
            d.fw    = '0;
            d.ph    = 1'b0;
        end else if (q.lost) begin
            if (hit) d.lost = 1'b0;
            if (line_start) begin
                if (fly_start) begin
                    d.fw = '0;
                    d.ph = ~q.ph;
                end else begin
                    d.fw = fw_inc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lost_pulse = q.pulse;

    // R4: loss pulse is one cycle wide
    p_lost_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |=> !q.pulse);
    // R6: a crossing leaves the lost state
    p_lost_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lost && hit) |=> !q.lost);
endmodule

// File: rtl/vsd_std_check.sv
module vsd_std_check #(
    parameter int LN_W       = 10,
    parameter int NTSC_MAX   = 285,
    parameter int MIS_FIELDS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic vs_start,
    input  logic std_sel,
    input  logic std_clr,
    input  logic lost_enter,
    output logic std_err
);
    localparam int              MIS_W  = $clog2(MIS_FIELDS + 1);
    localparam logic [MIS_W-1:0] MIS_V = MIS_W'(MIS_FIELDS);
    localparam logic [LN_W-1:0]  NTSC_V = LN_W'(NTSC_MAX);
    localparam logic [LN_W-1:0]  LN_MAX = '1;

    typedef struct packed {
        logic [LN_W-1:0]  lines;
        logic [MIS_W-1:0] mis;
        logic             ref_ok;
        logic             err;
    } sc_s;

    sc_s q, d;
    logic is_625, mismatch;
    logic [MIS_W-1:0] mis_inc;

    always_comb begin
        d        = q;
        is_625   = q.lines > NTSC_V;
        mismatch = is_625 != std_sel;
        mis_inc  = q.mis + 1'b1;

        if (vs_start)                               d.lines = '0;
        else if (line_start && (q.lines != LN_MAX)) d.lines = q.lines + 1'b1;

        if (vs_start) begin
            d.ref_ok = 1'b1;
            if (q.ref_ok) begin
                if (mismatch) begin
                    if (q.mis != MIS_V) d.mis = mis_inc;
                    if (mis_inc >= MIS_V) d.err = 1'b1;
                end else begin
                    d.mis = '0;
                end
            end
        end
        if (lost_enter) begin
            d.ref_ok = 1'b0;
            d.mis    = '0;
        end
        if (std_clr) begin
            d.err    = 1'b0;
            d.mis    = '0;
            d.ref_ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign std_err = q.err;

    // R8: error flag is sticky until cleared
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !std_clr) |=> q.err);
    // R7: flag only sets on a field boundary
    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> $past(vs_start));
endmodule

// File: rtl/vsd_detector.sv
module vsd_detector
    import vsd_pkg::*;
#(
    parameter int THR_W      = 10,
    parameter int POS_W      = 11,
    parameter int HALF_POS   = 429,
    parameter int LN_W       = 10,
    parameter int VS_LINES   = 6,
    parameter int LOST_LINES = 340,
    parameter int MIS_FIELDS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             sync_low,
    input  logic [THR_W-1:0] vs_thresh,
    input  logic             std_625,
    input  logic             std_clr,
    output logic             vsync,
    output logic             field,
    output logic             sync_lost,
    output logic             std_err
);
    localparam int               VSL_W = $clog2(VS_LINES + 1);
    localparam logic [VSL_W-1:0] VSL_V = VSL_W'(VS_LINES);

    typedef struct packed {
        logic             vs;
        logic [VSL_W-1:0] vsl;
        logic             field;
    } top_s;

    top_s q, d;
    vsd_std_e std_e;
    logic hit, hit_late, lost_enter, fly_start, vs_start, syn_start;
    logic [VSL_W-1:0] vsl_inc;

    assign std_e = vsd_std_e'(std_625);

    vsd_line_meter #(.THR_W(THR_W), .POS_W(POS_W), .HALF_POS(HALF_POS)) u_meter (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .sync_low(sync_low),
        .vs_thresh(vs_thresh), .hit(hit), .hit_late(hit_late)
    );

    vsd_flywheel #(.LN_W(LN_W), .LOST_LINES(LOST_LINES),
                   .BASE_525(VSD_BASE_525), .BASE_625(VSD_BASE_625)) u_fly (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .hit(hit),
        .std_sel(std_e == STD_625), .lost_enter(lost_enter),
        .lost_pulse(sync_lost), .fly_start(fly_start)
    );

    vsd_std_check #(.LN_W(LN_W), .NTSC_MAX(VSD_NTSC_MAX_LINES),
                    .MIS_FIELDS(MIS_FIELDS)) u_std (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .vs_start(vs_start),
        .std_sel(std_e == STD_625), .std_clr(std_clr), .lost_enter(lost_enter),
        .std_err(std_err)
    );

    always_comb begin
        d         = q;
        vs_start  = hit && !q.vs;
        syn_start = fly_start && !q.vs && !vs_start;
        vsl_inc   = q.vsl + 1'b1;
        if (vs_start) begin
            d.vs    = 1'b1;
            d.vsl   = '0;
            d.field = hit_late;
        end else if (syn_start) begin
            d.vs    = 1'b1;
            d.vsl   = '0;
            d.field = ~q.field;
        end else if (q.vs && line_start) begin
            if (vsl_inc == VSL_V) begin
                d.vs  = 1'b0;
                d.vsl = '0;
            end else begin
                d.vsl = vsl_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vsync = q.vs;
    assign field = q.field;

    // R1: a rise needs a crossing or a flywheel start
    p_vs_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.vs) |-> $past(hit || fly_start));
    // R2: vsync only ends on a line start
    p_vs_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.vs) |-> $past(line_start));
    // R3: parity moves only with a vsync rise
    p_field_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.field) |-> $rose(q.vs));
endmodule

// File: tb/vsd_detector_tb.sv
module vsd_detector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_CYC   = 32;
    localparam int HALF       = 16;
    localparam int THR        = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0, sync_low = 1'b0, std_625 = 1'b0, std_clr = 1'b0;
    logic [9:0] vs_thresh = 10'(THR);
    logic vsync, field, sync_lost, std_err;

    int checks = 0, errors = 0;
    int n_lost = 0, n_rise = 0;
    bit prev_vs = 1'b0, done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsd_detector #(.HALF_POS(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .sync_low(sync_low),
        .vs_thresh(vs_thresh), .std_625(std_625), .std_clr(std_clr),
        .vsync(vsync), .field(field), .sync_lost(sync_lost), .std_err(std_err)
    );

    // behavioural reference model
    int  m_low, m_pos, m_vsl, m_miss, m_fw, m_lines, m_mis;
    bit  m_crossed, m_vs, m_field, m_lost, m_pulse, m_ph, m_ref, m_err;

    always @(posedge clk) begin
        int nlow, npos, period;
        bit hit, late, lenter, fly, vstart, syn, big;
        if (!rst_n) begin
            m_low = 0; m_pos = 0; m_vsl = 0; m_miss = 0; m_fw = 0; m_lines = 0; m_mis = 0;
            m_crossed = 0; m_vs = 0; m_field = 0; m_lost = 0; m_pulse = 0; m_ph = 0;
            m_ref = 0; m_err = 0;
        end else begin
            nlow   = line_start ? int'(sync_low) : ((m_low + int'(sync_low)) > 1023 ? 1023 : m_low + int'(sync_low));
            npos   = line_start ? 0 : (m_pos < 2047 ? m_pos + 1 : m_pos);
            hit    = (nlow > int'(vs_thresh)) && (line_start || !m_crossed);
            late   = npos >= HALF;
            lenter = line_start && !hit && !m_lost && (m_miss + 1 == 340);
            period = (std_625 ? 312 : 262) + int'(m_ph);
            fly    = m_lost && line_start && (m_fw + 1 == period);
            vstart = hit && !m_vs;
            syn    = fly && !m_vs && !vstart;
            big    = m_lines > 285;
            // line meter
            m_low = nlow; m_pos = npos;
            m_crossed = line_start ? hit : (m_crossed | hit);
            // standard check (uses old m_lines via big)
            if (vstart) begin
                if (m_ref) begin
                    if (big != std_625) begin
                        if (m_mis < 2) m_mis++;
                        if (m_mis >= 2) m_err = 1;
                    end else m_mis = 0;
                end
                m_ref = 1; m_lines = 0;
            end else if (line_start && m_lines < 1023) m_lines++;
            if (lenter) begin m_ref = 0; m_mis = 0; end
            if (std_clr) begin m_err = 0; m_mis = 0; m_ref = 0; end
            // loss and flywheel
            m_pulse = lenter;
            if (lenter) begin m_lost = 1; m_fw = 0; m_ph = 0; end
            else if (m_lost) begin
                if (hit) m_lost = 0;
                if (line_start) begin
                    if (fly) begin m_fw = 0; m_ph = ~m_ph; end
                    else m_fw++;
                end
            end
            if (hit) m_miss = 0;
            else if (line_start && m_miss < 340) m_miss++;
            // vsync and field
            if (vstart) begin m_vs = 1; m_vsl = 0; m_field = late; end
            else if (syn) begin m_vs = 1; m_vsl = 0; m_field = ~m_field; end
            else if (m_vs && line_start) begin
                if (m_vsl + 1 == 6) begin m_vs = 0; m_vsl = 0; end
                else m_vsl++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            if (errors < 30) $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(vsync == m_vs,         "R1/R2 vsync",     int'(vsync),     int'(m_vs));
            check(field == m_field,      "R3 field",        int'(field),     int'(m_field));
            check(sync_lost == m_pulse,  "R4 sync_lost",    int'(sync_lost), int'(m_pulse));
            check(std_err == m_err,      "R7/R8 std_err",   int'(std_err),   int'(m_err));
            if (sync_lost) n_lost++;
            if (vsync && !prev_vs) n_rise++;
            prev_vs = vsync;
        end
    end

    task automatic run_line(input int ln, input bit even, input bit vs_on);
        for (int p = 0; p < LINE_CYC; p++) begin
            @(negedge clk);
            line_start = (p == 0);
            if (vs_on && ln < 3) sync_low = (ln == 0 && even) ? (p >= HALF) : (p < 28);
            else                 sync_low = (p < 3);
        end
    endtask

    task automatic run_field(input int nlines, input bit even, input bit vs_on, input int exp_field);
        for (int ln = 0; ln < nlines; ln++) begin
            run_line(ln, even, vs_on);
            if (ln == 3 && exp_field >= 0) begin
                @(negedge clk);
                check(field == exp_field[0], "R3 parity", int'(field), exp_field);
                check(vsync == 1'b1, "R2 vsync held", int'(vsync), 1);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(vsync == 0 && field == 0 && sync_lost == 0 && std_err == 0, "R9 in reset", int'(vsync), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(vsync == 0 && field == 0 && sync_lost == 0 && std_err == 0, "R9 after reset", int'(std_err), 0);
        // 525-line source, matching standard
        run_field(262, 1'b0, 1'b1, 0);
        run_field(263, 1'b1, 1'b1, 1);
        run_field(262, 1'b0, 1'b1, 0);
        check(std_err == 0, "R7 matching source", int'(std_err), 0);
        // 625-line source with 525 programmed
        run_field(313, 1'b1, 1'b1, 1);
        run_field(312, 1'b0, 1'b1, 0);
        check(std_err == 0, "R7 one mismatch only", int'(std_err), 0);
        run_field(313, 1'b1, 1'b1, 1);
        check(std_err == 1, "R7 two mismatches", int'(std_err), 1);
        run_line(5, 1'b0, 1'b0);
        check(std_err == 1, "R8 sticky", int'(std_err), 1);
        // clear together with switching the standard
        @(negedge clk); std_clr = 1'b1; std_625 = 1'b1;
        @(negedge clk); std_clr = 1'b0;
        @(negedge clk);
        check(std_err == 0, "R8 clear", int'(std_err), 0);
        run_field(312, 1'b0, 1'b1, 0);
        run_field(313, 1'b1, 1'b1, 1);
        run_field(312, 1'b0, 1'b1, 0);
        check(std_err == 0, "R8 no reset of flag after clear", int'(std_err), 0);
        // vertical sync removed: loss and flywheel
        n_lost = 0; n_rise = 0;
        for (int ln = 0; ln < 1000; ln++) run_line(ln, 1'b0, 1'b0);
        check(n_lost == 1, "R4 single loss pulse", n_lost, 1);
        check(n_rise == 3, "R5 flywheel starts", n_rise, 3);
        // vertical sync restored
        n_lost = 0;
        run_field(313, 1'b1, 1'b1, 1);
        run_field(312, 1'b0, 1'b1, 0);
        check(n_lost == 0, "R6 no loss after return", n_lost, 0);
        check(std_err == 0, "R7 reference restarted after loss", int'(std_err), 0);
        finish_run();
    end
endmodule